// File: doc/BRIEF.md
# Modem control line change detector

This block watches four active-low modem handshake inputs: carrier detect, ring indicator, data set ready and clear to send. It brings each raw pin into the clock domain through a synchroniser and reports the current level of each line in inverted form. For each line it also keeps a sticky flag that records a transition since the register was last read. All of this is presented as one read-only 8-bit status word.

Carrier detect, data set ready and clear to send flag a change in either direction. The ring indicator flags only the end of a ring, which is its pin returning from low to high.

A read strobe from the host clears the four flags at the end of the read cycle. If a new transition arrives in that same cycle, its flag stays set. With the interrupt enable high, the interrupt output stays high while any flag is set.

Top module: `modem_status_watch`

## Requirements
- R1: While reset is held and just after its release with all pins high, the status word is 0x00 and the interrupt output is low.
- R2: Status bits 7, 6, 5 and 4 hold the inverted synchronised levels of carrier detect, ring indicator, data set ready and clear to send. A pin change shows there two clock edges after it is driven.
- R3: Status bit 3 is set when the carrier-detect pin changes level in either direction. The flag appears three clock edges after the pin change and not earlier.
- R4: Status bit 2 is set only when the ring-indicator pin goes from low to high. A high-to-low change of that pin leaves bit 2 unchanged.
- R5: Status bit 1 is set on any change of the data-set-ready pin, and status bit 0 on any change of the clear-to-send pin.
- R6: While the read strobe is high, the status word shows the current levels and flags. The clock edge that ends the read cycle clears bits 3 to 0 and leaves bits 7 to 4 unchanged.
- R7: A flag whose transition is detected in the same cycle as a read stays set after that read, while the other flags clear.
- R8: The interrupt output is high exactly when the interrupt enable is high and at least one of bits 3 to 0 is set.
- R9: The status word has no write path, and the whole word holds 0x00 after reset.
- R10: A flag, once set, stays set through further transitions on any line until a read clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dcd_n | input | 1 | Raw carrier-detect pin, active low, asynchronous |
| ri_n | input | 1 | Raw ring-indicator pin, active low, asynchronous |
| dsr_n | input | 1 | Raw data-set-ready pin, active low, asynchronous |
| cts_n | input | 1 | Raw clear-to-send pin, active low, asynchronous |
| rd_stb | input | 1 | Host read of the status word; clears the flags at the end of the cycle |
| irq_en | input | 1 | Enables the modem-status interrupt |
| rd_data | output | 8 | Status word: inverted levels in 7:4, change flags in 3:0 |
| irq | output | 1 | Modem-status interrupt |

## Verification
A pin driven between clock edges reaches the level bits after the second rising edge. It reaches the change flags and the interrupt after the third. A read clears the flags on the first rising edge after the strobe is raised. The bench drives every input just after a falling edge and samples one time unit later. It checks the flags after exactly two edges, when they must still be clear, and again after three, when they must have arrived. It sweeps all 256 ordered pairs of pin patterns and computes the expected flags from the two patterns. The coincident-read case is run by raising the strobe after the second edge, which is the one cycle in which the detector is firing.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  typedef enum logic {
    DET_ANY  = 1'b0,   // any level change
    DET_RISE = 1'b1    // pin low-to-high only (end of an active-low pulse)
  } det_mode_e;

  localparam int LINES    = 4;
  localparam int IDX_DCD  = 3;
  localparam int IDX_RI   = 2;
  localparam int IDX_DSR  = 1;
  localparam int IDX_CTS  = 0;

  function automatic logic edge_hit(det_mode_e mode, logic prev, logic cur);
    if (mode == DET_RISE) return (!prev) && cur;
    return prev ^ cur;
  endfunction

  function automatic logic [7:0] pack_status(logic [LINES-1:0] lvl_n,
                                             logic [LINES-1:0] flg);
    return {~lvl_n, flg};
  endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[LAST];

  generate
    if (STAGES >= 2) begin : g_chk
      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> dout == $past(pipe[STAGES-2])); // R2
    end
  endgenerate

endmodule

// File: rtl/mdm_change_flag.sv
module mdm_change_flag
  import mdm_pkg::*;
#(
  parameter det_mode_e MODE = DET_ANY
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,    // synchronised pin level
  input  logic clr,    // host read
  output logic evt,    // transition seen this cycle
  output logic flag
);
  logic prev;

  assign evt = edge_hit(MODE, prev, lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b1;
      flag <= 1'b0;
    end else begin
      prev <= lvl;
      if (evt)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    flag && !clr |=> flag); // R10
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    clr && !evt |=> !flag); // R6

endmodule

// File: rtl/modem_status_watch.sv
module modem_status_watch
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dcd_n,
  input  logic       ri_n,
  input  logic       dsr_n,
  input  logic       cts_n,
  input  logic       rd_stb,
  input  logic       irq_en,
  output logic [7:0] rd_data,
  output logic       irq
);
  logic [LINES-1:0] raw_n;
  logic [LINES-1:0] lvl_n;
  logic [LINES-1:0] chg_evt;
  logic [LINES-1:0] chg_flag;
  logic             any_flag;

  always_comb begin
    raw_n[IDX_DCD] = dcd_n;
    raw_n[IDX_RI]  = ri_n;
    raw_n[IDX_DSR] = dsr_n;
    raw_n[IDX_CTS] = cts_n;
  end

  mdm_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_n),
    .dout (lvl_n)
  );

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      localparam det_mode_e LMODE = (i == IDX_RI) ? DET_RISE : DET_ANY;
      mdm_change_flag #(.MODE(LMODE)) u_flag (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl_n[i]),
        .clr  (rd_stb),
        .evt  (chg_evt[i]),
        .flag (chg_flag[i])
      );
    end
  endgenerate

  assign any_flag = |chg_flag;
  assign rd_data  = pack_status(lvl_n, chg_flag);
  assign irq      = irq_en && any_flag;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> rd_data[3:0] != 4'b0); // R8
  AST_RING_END_ONLY: assert property (@(posedge clk) disable iff (rst)
    chg_evt[IDX_RI] |-> !rd_data[6]); // R4
  AST_LEVELS_SURVIVE_READ: assert property (@(posedge clk) disable iff (rst)
    rd_stb && $stable(lvl_n) |-> rd_data[7:4] == ~lvl_n); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> rd_data == 8'h00); // R9

endmodule

// File: tb/test_modem_status_watch.sv
module test_modem_status_watch;

  logic       clk = 1'b0;
  logic       rst;
  logic       dcd_n, ri_n, dsr_n, cts_n;
  logic       rd_stb, irq_en;
  logic [7:0] rd_data;
  logic       irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  modem_status_watch i_modem_status_watch (
    .clk(clk), .rst(rst),
    .dcd_n(dcd_n), .ri_n(ri_n), .dsr_n(dsr_n), .cts_n(cts_n),
    .rd_stb(rd_stb), .irq_en(irq_en),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // pattern order {dcd, ri, dsr, cts}
  task automatic drive(logic [3:0] p);
    {dcd_n, ri_n, dsr_n, cts_n} = p;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] exp_flags(logic [3:0] a, logic [3:0] b);
    logic [3:0] f;
    f[3] = a[3] != b[3];
    f[2] = (a[2] == 1'b0) && (b[2] == 1'b1);
    f[1] = a[1] != b[1];
    f[0] = a[0] != b[0];
    return f;
  endfunction

  task automatic clear_read();
    rd_stb = 1'b1;
    cyc(1);
    rd_stb = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rd_stb = 1'b0; irq_en = 1'b1;
    drive(4'b1111);
    cyc(3); #1;
    chk("R1 reset word", rd_data, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    rst = 1'b0;
    cyc(4); #1;
    chk("R1 after release", rd_data, 8'h00);
    chk("R9 word after reset", rd_data, 8'h00);

    // exhaustive sweep of pattern pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0] pa, pb, ef;
        pa = 4'(a); pb = 4'(b);
        ef = exp_flags(pa, pb);
        drive(pa); cyc(4); #1;
        clear_read(); #1;
        irq_en = ((a + b) % 3) != 0;
        drive(pb);
        cyc(2); #1;
        chk("R2 levels", {4'b0, rd_data[7:4]}, {4'b0, ~pb});
        chk("R3 R5 no flag before third edge", {4'b0, rd_data[3:0]}, 8'h00);
        cyc(1); #1;
        chk("R3 R4 R5 flags", {4'b0, rd_data[3:0]}, {4'b0, ef});
        chk("R8 irq", {7'b0, irq}, {7'b0, irq_en && (ef != 4'b0)});
        rd_stb = 1'b1; #1;
        chk("R6 read value", rd_data, {~pb, ef});
        cyc(1);
        rd_stb = 1'b0; #1;
        chk("R6 after read", rd_data, {~pb, 4'b0000});
        chk("R8 irq after read", {7'b0, irq}, 8'h00);
      end
    end

    // sticky flag and ring leading edge
    irq_en = 1'b1;
    drive(4'b1111); cyc(4); clear_read(); #1;
    drive(4'b0111); cyc(4);
    drive(4'b1111); cyc(4); #1;
    chk("R10 dcd flag kept after two changes", rd_data, 8'h08);
    drive(4'b1011); cyc(4); #1;
    chk("R4 ring leading edge ignored", rd_data, 8'h48);
    drive(4'b1111); cyc(4); #1;
    chk("R4 ring trailing edge", rd_data, 8'h0C);
    chk("R8 irq with flags", {7'b0, irq}, 8'h01);
    irq_en = 1'b0; #1;
    chk("R8 irq masked", {7'b0, irq}, 8'h00);
    irq_en = 1'b1;

    // read coincident with a detected change
    cyc(1); clear_read(); #1;
    drive(4'b1110); cyc(4); #1;
    chk("R5 cts flag", rd_data, 8'h11);
    drive(4'b0110); cyc(2);
    rd_stb = 1'b1;
    cyc(1);
    rd_stb = 1'b0; #1;
    chk("R7 coincident flag kept", rd_data, 8'h98);
    cyc(1); clear_read(); #1;
    chk("R6 cleared afterwards", rd_data, 8'h90);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule